// File: doc/BRIEF.md
# Read-When-Stable Detector

This block decides when a filtered weight reading may be trusted. It watches a stream of signed samples, each marked by a valid strobe, and raises a stable flag only when the samples gathered since the last disturbance meet three tests at once. There must be enough of them. The net drift from the first to the newest must be small. The distance between the highest and lowest sample must also be small.

A single out-of-bounds sample drops the flag and starts a fresh window. This means an impact spike, a rebound tail still creeping toward its final value, or ongoing vibration is never taken as a settled weight. The batching controller that uses the flag is outside this block.

Each time the flag rises, the block records which sample triggered it. It also keeps the drift and range values seen on that sample, so every accepted reading carries evidence of how quiet it was.

Top module: `settle_gate`

## Requirements
- R1: While reset is asserted and directly after it, `stable` is 0 and `stamp`, `snap_slope` and `snap_spread` are all 0.
- R2: A cycle with `in_valid` low changes no output, and it advances neither the window length nor the sample index, whatever `in_sample` holds.
- R3: The window length N is `cfg_window` clamped to the range 4..256. It is captured when a window starts, and a change made in mid-window takes effect only at the next restart.
- R4: The drift of a sample is that sample minus the first sample of the window. A sample with |drift| greater than `cfg_slope_lim` is a violation, and |drift| equal to the limit passes.
- R5: The range of a sample is the maximum minus the minimum over the window including that sample. A range greater than `cfg_spread_lim` is a violation, and a range equal to the limit passes.
- R6: A violating sample clears `stable` and becomes the first sample of a new window, which then holds one sample.
- R7: `stable` rises on the valid sample that completes N in-limit samples in the window. It then stays high while further samples stay within the limits.
- R8: Valid samples are numbered from 0 after reset, and the count wraps at 2^TS_W. When `stable` rises, `stamp` takes the number of the triggering sample, and `snap_slope` and `snap_spread` take its drift and range. All three hold their values at every other time.
- R9: Every output reflects a sample in the cycle after the clock edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Qualifies `in_sample` this cycle |
| in_sample | input | DATA_W | Filtered weight sample, signed |
| cfg_window | input | CNT_W (9) | Requested window length, clamped to 4..256 |
| cfg_slope_lim | input | DATA_W | Largest allowed absolute drift |
| cfg_spread_lim | input | DATA_W | Largest allowed range |
| stable | output | 1 | Reading is settled |
| stamp | output | TS_W | Index of the sample that last raised `stable` |
| snap_slope | output | DATA_W+1 | Drift at the last rise, signed |
| snap_spread | output | DATA_W+1 | Range at the last rise |

## Verification
Each result belongs to the clock edge that accepts the sample, so `stable`, `stamp` and both snapshots are due exactly one edge after `in_valid` is presented. The bench drives a sample on the falling edge and compares all four outputs shortly after the following rising edge, before the next sample is driven. The window-length cases count valid samples and compare on the sample just before the N-th and on the N-th itself. This pins the rise to one particular sample, not just to some cycle.

// File: rtl/sg_pkg.sv
package sg_pkg;
  // Detector phase: hunting for a quiet window, or locked on one.
  typedef enum logic {
    SG_SEEK = 1'b0,
    SG_LOCK = 1'b1
  } sg_phase_e;
endpackage

// File: rtl/sg_extent.sv
// Tracks first sample, running maximum and minimum of the current window.
module sg_extent #(
  parameter int DATA_W = 24,
  localparam int MAG_W = DATA_W + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     smp_en,
  input  logic                     load,
  input  logic signed [DATA_W-1:0] sample,
  output logic signed [MAG_W-1:0]  slope_acc,
  output logic        [MAG_W-1:0]  spread_acc
);
  logic signed [DATA_W-1:0] first_q, hi_q, lo_q;
  logic signed [DATA_W-1:0] first_d, hi_d, lo_d;
  logic signed [DATA_W-1:0] hi_c, lo_c;
  logic signed [MAG_W-1:0]  hi_x, lo_x;

  // Candidate statistics assuming the sample joins the existing window.
  always_comb begin
    hi_c       = (sample > hi_q) ? sample : hi_q;
    lo_c       = (sample < lo_q) ? sample : lo_q;
    hi_x       = MAG_W'(hi_c);
    lo_x       = MAG_W'(lo_c);
    slope_acc  = MAG_W'(sample) - MAG_W'(first_q);
    spread_acc = $unsigned(hi_x - lo_x);
  end

  always_comb begin
    first_d = first_q;
    hi_d    = hi_q;
    lo_d    = lo_q;
    if (smp_en) begin
      if (load) begin
        first_d = sample;
        hi_d    = sample;
        lo_d    = sample;
      end else begin
        hi_d = hi_c;
        lo_d = lo_c;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= '0;
      hi_q    <= '0;
      lo_q    <= '0;
    end else if (smp_en) begin
      first_q <= first_d;
      hi_q    <= hi_d;
      lo_q    <= lo_d;
    end
  end
endmodule

// File: rtl/sg_limits.sv
// Compares drift magnitude and range against their configured bounds.
module sg_limits #(
  parameter int DATA_W = 24,
  localparam int MAG_W = DATA_W + 1
) (
  input  logic signed [MAG_W-1:0]  slope,
  input  logic        [MAG_W-1:0]  spread,
  input  logic        [DATA_W-1:0] slope_lim,
  input  logic        [DATA_W-1:0] spread_lim,
  output logic                     slope_bad,
  output logic                     spread_bad
);
  logic [MAG_W-1:0] slope_mag;

  always_comb begin
    slope_mag  = slope[MAG_W-1] ? (~$unsigned(slope) + MAG_W'(1)) : $unsigned(slope);
    slope_bad  = slope_mag > {1'b0, slope_lim};
    spread_bad = spread > {1'b0, spread_lim};
  end
endmodule

// File: rtl/sg_window.sv
// Counts in-limit samples of the window and latches its clamped length.
module sg_window #(
  parameter int N_MIN = 4,
  parameter int N_MAX = 256,
  localparam int CNT_W = $clog2(N_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_en,
  input  logic             restart,
  input  logic [CNT_W-1:0] cfg_window,
  output logic             empty,
  output logic             full_c
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] len_q, len_d;
  logic [CNT_W-1:0] len_req;
  logic [CNT_W:0]   cnt_inc;

  always_comb begin
    if (cfg_window < CNT_W'(N_MIN))      len_req = CNT_W'(N_MIN);
    else if (cfg_window > CNT_W'(N_MAX)) len_req = CNT_W'(N_MAX);
    else                                 len_req = cfg_window;
  end

  always_comb begin
    empty   = (cnt_q == '0);
    cnt_inc = {1'b0, cnt_q} + (CNT_W+1)'(1);
    full_c  = !restart && (cnt_inc >= {1'b0, len_q});
    cnt_d   = cnt_q;
    len_d   = len_q;
    if (smp_en) begin
      if (restart) begin
        cnt_d = CNT_W'(1);
        len_d = len_req;
      end else if (cnt_q != len_q) begin
        cnt_d = cnt_inc[CNT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      len_q <= CNT_W'(N_MIN);
    end else if (smp_en) begin
      cnt_q <= cnt_d;
      len_q <= len_d;
    end
  end
endmodule

// File: rtl/sg_stamp.sv
// Free-running index of accepted samples.
module sg_stamp #(
  parameter int TS_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            smp_en,
  output logic [TS_W-1:0] idx
);
  logic [TS_W-1:0] idx_d;

  always_comb idx_d = idx + TS_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx <= '0;
    else if (smp_en) idx <= idx_d;
  end
endmodule

// File: rtl/settle_gate.sv
module settle_gate #(
  parameter int DATA_W = 24,
  parameter int TS_W   = 32,
  parameter int N_MIN  = 4,
  parameter int N_MAX  = 256,
  localparam int CNT_W = $clog2(N_MAX + 1),
  localparam int MAG_W = DATA_W + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_sample,
  input  logic        [CNT_W-1:0]  cfg_window,
  input  logic        [DATA_W-1:0] cfg_slope_lim,
  input  logic        [DATA_W-1:0] cfg_spread_lim,
  output logic                     stable,
  output logic        [TS_W-1:0]   stamp,
  output logic signed [MAG_W-1:0]  snap_slope,
  output logic        [MAG_W-1:0]  snap_spread
);
  import sg_pkg::*;

  logic signed [MAG_W-1:0] slope_acc;
  logic        [MAG_W-1:0] spread_acc;
  logic                    slope_bad, spread_bad;
  logic                    win_empty, win_full;
  logic                    violate, restart, rise;
  logic        [TS_W-1:0]  smp_idx;
  sg_phase_e               phase_q, phase_d;
  logic        [TS_W-1:0]  stamp_d;
  logic signed [MAG_W-1:0] snap_slope_d;
  logic        [MAG_W-1:0] snap_spread_d;

  sg_extent #(.DATA_W(DATA_W)) u_extent (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_en     (in_valid),
    .load       (restart),
    .sample     (in_sample),
    .slope_acc  (slope_acc),
    .spread_acc (spread_acc)
  );

  sg_limits #(.DATA_W(DATA_W)) u_limits (
    .slope      (slope_acc),
    .spread     (spread_acc),
    .slope_lim  (cfg_slope_lim),
    .spread_lim (cfg_spread_lim),
    .slope_bad  (slope_bad),
    .spread_bad (spread_bad)
  );

  sg_window #(.N_MIN(N_MIN), .N_MAX(N_MAX)) u_window (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_en     (in_valid),
    .restart    (restart),
    .cfg_window (cfg_window),
    .empty      (win_empty),
    .full_c     (win_full)
  );

  sg_stamp #(.TS_W(TS_W)) u_stamp (
    .clk    (clk),
    .rst_n  (rst_n),
    .smp_en (in_valid),
    .idx    (smp_idx)
  );

  // An empty window is opened by the sample; a violation reopens it.
  always_comb begin
    violate = !win_empty && (slope_bad || spread_bad);
    restart = win_empty || violate;
  end

  always_comb begin
    phase_d = phase_q;
    if (in_valid) begin
      if (restart)       phase_d = SG_SEEK;
      else if (win_full) phase_d = SG_LOCK;
    end
    rise          = in_valid && (phase_q == SG_SEEK) && (phase_d == SG_LOCK);
    stamp_d       = rise ? smp_idx    : stamp;
    snap_slope_d  = rise ? slope_acc  : snap_slope;
    snap_spread_d = rise ? spread_acc : snap_spread;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q     <= SG_SEEK;
      stamp       <= '0;
      snap_slope  <= '0;
      snap_spread <= '0;
    end else if (in_valid) begin
      phase_q     <= phase_d;
      stamp       <= stamp_d;
      snap_slope  <= snap_slope_d;
      snap_spread <= snap_spread_d;
    end
  end

  assign stable = (phase_q == SG_LOCK);
endmodule

// File: rtl/settle_gate_chk.sv
module settle_gate_chk #(
  parameter int DATA_W = 24,
  parameter int TS_W   = 32,
  parameter int CNT_W  = 9,
  localparam int MAG_W = DATA_W + 1
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_valid,
  input logic        [DATA_W-1:0] cfg_slope_lim,
  input logic        [DATA_W-1:0] cfg_spread_lim,
  input logic                     stable,
  input logic        [TS_W-1:0]   stamp,
  input logic signed [MAG_W-1:0]  snap_slope,
  input logic        [MAG_W-1:0]  snap_spread
);
  logic [MAG_W-1:0] snap_mag;
  always_comb snap_mag = snap_slope[MAG_W-1] ? (~$unsigned(snap_slope) + MAG_W'(1))
                                             : $unsigned(snap_slope);

  AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(stable) && $stable(stamp)); // R2

  AST_RISE_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stable) |-> $past(in_valid)); // R7

  AST_RISE_SLOPE_OK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stable) |-> snap_mag <= {1'b0, $past(cfg_slope_lim)}); // R4

  AST_RISE_SPREAD_OK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stable) |-> snap_spread <= {1'b0, $past(cfg_spread_lim)}); // R5

  AST_SNAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(stable) |-> $stable(stamp) && $stable(snap_slope) && $stable(snap_spread)); // R8
endmodule

bind settle_gate settle_gate_chk #(.DATA_W(DATA_W), .TS_W(TS_W), .CNT_W(CNT_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .in_valid       (in_valid),
  .cfg_slope_lim  (cfg_slope_lim),
  .cfg_spread_lim (cfg_spread_lim),
  .stable         (stable),
  .stamp          (stamp),
  .snap_slope     (snap_slope),
  .snap_spread    (snap_spread)
);

// File: tb/tb_settle_gate.sv
module tb_settle_gate;
  localparam int DATA_W = 24;
  localparam int TS_W   = 32;
  localparam int CNT_W  = 9;
  localparam int MAG_W  = DATA_W + 1;
  localparam int NV     = 19;

  typedef struct packed {
    logic                    v;
    logic signed [DATA_W-1:0] s;
    logic                    st;
    logic [TS_W-1:0]         ts;
    logic signed [MAG_W-1:0] sl;
    logic [MAG_W-1:0]        sp;
  } vec_t;

  // Limits: window 4, drift 10, range 15.
  localparam vec_t VEC [NV] = '{
    '{1'b1, 24'sd100,  1'b0, 32'd0,  25'sd0, 25'd0},   // R3 window opens
    '{1'b1, 24'sd102,  1'b0, 32'd0,  25'sd0, 25'd0},
    '{1'b1, 24'sd98,   1'b0, 32'd0,  25'sd0, 25'd0},
    '{1'b1, 24'sd101,  1'b1, 32'd3,  25'sd1, 25'd4},   // R7 fourth sample
    '{1'b1, 24'sd99,   1'b1, 32'd3,  25'sd1, 25'd4},   // R7 held
    '{1'b0, 24'sd9999, 1'b1, 32'd3,  25'sd1, 25'd4},   // R2 ignored
    '{1'b1, 24'sd150,  1'b0, 32'd3,  25'sd1, 25'd4},   // R6 spike clears
    '{1'b1, 24'sd152,  1'b0, 32'd3,  25'sd1, 25'd4},
    '{1'b1, 24'sd149,  1'b0, 32'd3,  25'sd1, 25'd4},
    '{1'b1, 24'sd151,  1'b1, 32'd8,  25'sd1, 25'd3},   // R8 index skips idle
    '{1'b1, 24'sd160,  1'b1, 32'd8,  25'sd1, 25'd3},   // R4 drift = limit
    '{1'b1, 24'sd161,  1'b0, 32'd8,  25'sd1, 25'd3},   // R4 drift over
    '{1'b1, 24'sd171,  1'b0, 32'd8,  25'sd1, 25'd3},
    '{1'b1, 24'sd156,  1'b0, 32'd8,  25'sd1, 25'd3},   // R5 range = limit
    '{1'b1, 24'sd165,  1'b1, 32'd13, 25'sd4, 25'd15},
    '{1'b1, 24'sd155,  1'b0, 32'd13, 25'sd4, 25'd15},  // R5 range over
    '{1'b1, 24'sd155,  1'b0, 32'd13, 25'sd4, 25'd15},
    '{1'b1, 24'sd155,  1'b0, 32'd13, 25'sd4, 25'd15},
    '{1'b1, 24'sd155,  1'b1, 32'd17, 25'sd0, 25'd0}
  };

  logic                     clk;
  logic                     rst_n;
  logic                     in_valid;
  logic signed [DATA_W-1:0] in_sample;
  logic        [CNT_W-1:0]  cfg_window;
  logic        [DATA_W-1:0] cfg_slope_lim;
  logic        [DATA_W-1:0] cfg_spread_lim;
  logic                     stable;
  logic        [TS_W-1:0]   stamp;
  logic signed [MAG_W-1:0]  snap_slope;
  logic        [MAG_W-1:0]  snap_spread;

  int nvec;
  int nfail;
  bit done;

  settle_gate dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_valid       (in_valid),
    .in_sample      (in_sample),
    .cfg_window     (cfg_window),
    .cfg_slope_lim  (cfg_slope_lim),
    .cfg_spread_lim (cfg_spread_lim),
    .stable         (stable),
    .stamp          (stamp),
    .snap_slope     (snap_slope),
    .snap_spread    (snap_spread)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input longint act, input longint exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_all(input string req, input logic st, input logic [TS_W-1:0] ts,
                           input logic signed [MAG_W-1:0] sl, input logic [MAG_W-1:0] sp);
    check({req, " stable"}, longint'(stable), longint'(st));
    check({req, " stamp"},  longint'(stamp),  longint'(ts));
    check({req, " slope"},  longint'(snap_slope), longint'(sl));
    check({req, " spread"}, longint'(snap_spread), longint'(sp));
  endtask

  // Drive on the falling edge, look one edge later (R9).
  task automatic step(input logic v, input logic signed [DATA_W-1:0] s);
    @(negedge clk);
    in_valid  = v;
    in_sample = s;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_sample = '0;
    cfg_window = 9'd4;
    cfg_slope_lim = 24'd10;
    cfg_spread_lim = 24'd15;
    nvec = 0;
    nfail = 0;
    done = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check_all("R1 in reset", 1'b0, '0, '0, '0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check_all("R1 after reset", 1'b0, '0, '0, '0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].v, VEC[i].s);
      check_all($sformatf("R9 vector %0d", i), VEC[i].st, VEC[i].ts, VEC[i].sl, VEC[i].sp);
    end

    // R3: new length while locked is not applied until the window restarts.
    cfg_window = 9'd8;
    step(1'b1, 24'sd156);                       // idx 18
    check_all("R3 change while locked", 1'b1, 32'd17, 25'sd0, 25'd0);
    step(1'b1, 24'sd200);                       // idx 19 restart, N=8
    check("R6 restart", longint'(stable), 0);
    for (int k = 0; k < 6; k++) step(1'b1, 24'sd200);   // idx 20..25
    check("R3 seven of eight", longint'(stable), 0);
    step(1'b1, 24'sd200);                       // idx 26
    check_all("R3 eighth sample", 1'b1, 32'd26, 25'sd0, 25'd0);

    // R3: request below 4 clamps to 4.
    cfg_window = 9'd1;
    step(1'b1, 24'sd300);                       // idx 27 restart
    step(1'b1, 24'sd300);
    step(1'b1, 24'sd300);                       // idx 29
    check("R3 low clamp three", longint'(stable), 0);
    step(1'b1, 24'sd300);                       // idx 30
    check_all("R3 low clamp four", 1'b1, 32'd30, 25'sd0, 25'd0);

    // R3: request above 256 clamps to 256.
    cfg_window = 9'd511;
    step(1'b1, 24'sd0);                         // idx 31 restart
    for (int k = 0; k < 254; k++) step(1'b1, 24'sd0);   // idx 32..285
    check("R3 high clamp 255", longint'(stable), 0);
    step(1'b1, 24'sd0);                         // idx 286
    check_all("R3 high clamp 256", 1'b1, 32'd286, 25'sd0, 25'd0);

    // R2: idle cycles with garbage data change nothing.
    idle();
    in_sample = -24'sd5000;
    repeat (4) @(posedge clk);
    #1;
    check_all("R2 idle garbage", 1'b1, 32'd286, 25'sd0, 25'd0);

    // R1: reset in mid-run clears everything.
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_all("R1 mid-run reset", 1'b0, '0, '0, '0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule